// File: doc/BRIEF.md
# Converter Command and Result Queue Controller

This block fronts an on-chip model of 128 sixteen-bit converter registers with a small word-addressed register bus. Software sends commands by writing one word into a command port. Each command is a no-op, a read of one converter register or a write of one converter register. Each command executes in the same cycle in which it is written.

Read data comes back one command late. Every command pushes the result held from the most recent earlier read into a 15-entry result queue. Software then drains that queue through a second port. To collect the value of a read, software issues one more command after it, which is usually a no-op.

The block also holds a configuration word, sticky interrupt flags with a mask, a live status word and a control word that flushes the queue. A single level interrupt output is active while any flag is set and not masked. Each flag source has its own trigger: the queue level rising above a programmed threshold, the command queue sitting below its own threshold, or one of eight alarm inputs.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0x00001114, the mask reads 0x3FF, the interrupt flags read 0, the status word reads 0x0500 and `irq` is low.
- R2: Every command pushes the stored read result into the result queue. A read command (opcode field bits 29:26 = 1) then replaces the stored result with the register addressed by bits 22:16. The stored result is 0 after reset.
- R3: A write command (opcode 2) stores bits 15:0 into the register addressed by bits 22:16. A later read of that register returns the new value.
- R4: Opcode 0, and every opcode from 3 to 15, only pushes the stored result. It changes neither the register bank nor the stored result.
- R5: The result queue returns entries in push order through word 5, in the low 16 bits. Status bits 15:12 give its level, bit 9 flags it full and bit 8 flags it empty. Bits 10 and 11 report an always-empty, never-full command queue.
- R6: Reading word 5 while the queue is empty returns 0 and leaves the level at 0.
- R7: A command issued while the queue holds 15 entries drops its push, and the level stays at 15.
- R8: Interrupt flag bit 8 sets when the queue level exceeds the threshold in configuration bits 19:16. Writing 1s to the flag word (word 1) clears those bits, and a bit whose condition still holds sets again.
- R9: Interrupt flag bit 9 sets while the command queue level, which is always 0, is below the threshold in configuration bits 23:20.
- R10: The mask (word 2) keeps only bits 9:0 of a write. `irq` is high exactly when some flag bit is set and its mask bit is 0.
- R11: Writing control word 6 with bit 4 set empties the result queue. The stored read result is kept.
- R12: Each `alarm_in` bit sets the matching flag bit 7:0, which stays set after the input falls. Status bits 7:0 show `alarm_in` live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word index: 0 config, 1 flags, 2 mask, 3 status, 4 command, 5 result, 6 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| alarm_in | input | 8 | Alarm sources |
| irq | output | 1 | Level interrupt |

## Verification
If the stored read result is wrong, the error shows up in the queue entry pushed by the next command, not by the read itself. So every lag check pairs a read with the command that follows it. Corrupted queue pointers or a corrupted level show up in the next status read as a wrong level or wrong flag bits, or as out-of-order pops. A flag that fails to set or clear changes `irq` and the flag word one edge after its cause.

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl #(
  parameter int AW    = 7,
  parameter int DW    = 16,
  parameter int DEPTH = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  alarm_in,
  output logic        irq
);
  localparam int NREG  = 1 << AW;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [31:0] CFG_RST = 32'h0000_1114;
  localparam logic [2:0] A_CFG = 3'd0, A_IST = 3'd1, A_MSK = 3'd2, A_STS = 3'd3,
                         A_CMD = 3'd4, A_DAT = 3'd5, A_CTL = 3'd6;
  localparam logic [3:0] OP_RD = 4'd1, OP_WR = 4'd2;

  logic [DW-1:0]    bank [NREG];
  logic [DW-1:0]    fifo [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] lvl;
  logic [DW-1:0]    last_rd;
  logic [31:0]      cfg_q, ctl_q;
  logic [9:0]       ist_q, mask_q;

  wire wr_acc = bus_en & bus_we;
  wire rd_acc = bus_en & ~bus_we;
  wire cmd_go = wr_acc && bus_addr == A_CMD;
  wire [3:0]    op    = bus_wdata[29:26];
  wire [AW-1:0] caddr = bus_wdata[16 +: AW];
  wire [DW-1:0] cdata = bus_wdata[DW-1:0];

  wire empty = lvl == '0;
  wire full  = lvl == LVL_W'(DEPTH);
  wire push  = cmd_go && !full;
  wire pop   = rd_acc && bus_addr == A_DAT && !empty;
  wire flush = wr_acc && bus_addr == A_CTL && bus_wdata[4];

  wire [3:0] cmd_thr = cfg_q[23:20];
  wire [3:0] dat_thr = cfg_q[19:16];
  wire [3:0] cmd_lvl = 4'd0;
  wire [3:0] lvl4    = 4'(lvl);

  wire [9:0] ist_set = {cmd_lvl < cmd_thr, lvl4 > dat_thr, alarm_in};
  wire [9:0] ist_clr = (wr_acc && bus_addr == A_IST) ? bus_wdata[9:0] : 10'd0;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl    <= '0;
    end else if (push) begin
      wr_ptr <= nxt(wr_ptr);
      lvl    <= lvl + 1'b1;
    end else if (pop) begin
      rd_ptr <= nxt(rd_ptr);
      lvl    <= lvl - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) fifo[wr_ptr] <= last_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      last_rd <= '0;
    end else if (cmd_go) begin
      if (op == OP_RD) last_rd <= bank[caddr];
      if (op == OP_WR) bank[caddr] <= cdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      ctl_q  <= '0;
      mask_q <= 10'h3ff;
      ist_q  <= '0;
    end else begin
      if (wr_acc && bus_addr == A_CFG) cfg_q <= bus_wdata;
      if (wr_acc && bus_addr == A_CTL) ctl_q <= bus_wdata;
      if (wr_acc && bus_addr == A_MSK) mask_q <= bus_wdata[9:0];
      ist_q <= (ist_q & ~ist_clr) | ist_set;
    end
  end

  wire [31:0] status = {16'd0, lvl4, 1'b0, 1'b1, full, empty, alarm_in};
  wire [DW-1:0] head = empty ? '0 : fifo[rd_ptr];

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_IST:   bus_rdata = {22'd0, ist_q};
      A_MSK:   bus_rdata = {22'd0, mask_q};
      A_STS:   bus_rdata = status;
      A_DAT:   bus_rdata = 32'(head);
      A_CTL:   bus_rdata = ctl_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(ist_q & ~mask_q);
endmodule

module adc_cmd_ctrl_chk #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic [LVL_W-1:0] lvl,
  input logic [9:0]       mask_q
);
  wire cmd_w   = bus_en && bus_we && bus_addr == 3'd4;
  wire pop_r   = bus_en && !bus_we && bus_addr == 3'd5;
  wire flush_w = bus_en && bus_we && bus_addr == 3'd6 && bus_wdata[4];

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && lvl < LVL_W'(DEPTH)) |=> lvl == $past(lvl) + 1'b1);
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && lvl == LVL_W'(DEPTH)) |=> lvl == LVL_W'(DEPTH));
  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_r && lvl == '0) |-> (bus_rdata == 32'd0) ##1 (lvl == '0));
  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> lvl == '0);
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 10'h3ff) |-> !irq);
endmodule

bind adc_cmd_ctrl adc_cmd_ctrl_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .lvl(lvl), .mask_q(mask_q));

// File: tb/adc_cmd_ctrl_tb.sv
module adc_cmd_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  alarm_in = 0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_cmd_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_in(alarm_in), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [6:0] a, input logic [15:0] d);
    wr(3'd4, {2'b00, op, 3'b000, a, d});
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 cfg", 3'd0, 32'h0000_1114);
    expect_rd("R1 mask", 3'd2, 32'h3ff);
    expect_rd("R1 flags", 3'd1, 32'h0);
    expect_rd("R1 status", 3'd3, 32'h0500);
    check("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_lag;
    cmd(4'd2, 7'd5, 16'hABCD);
    cmd(4'd1, 7'd5, 16'h0);
    cmd(4'd0, 7'd0, 16'h0);
    expect_rd("R5 level 3", 3'd3, 32'h3400);
    expect_rd("R2 first push is 0", 3'd5, 32'h0);
    expect_rd("R2 read cmd pushes old", 3'd5, 32'h0);
    expect_rd("R3 lagged read data", 3'd5, 32'h0000ABCD);
    expect_rd("R5 empty after drain", 3'd3, 32'h0500);
  endtask

  task automatic t_ops;
    cmd(4'd0, 7'd0, 16'h0);
    wr(3'd6, 32'h10);
    expect_rd("R11 flushed", 3'd3, 32'h0500);
    cmd(4'd2, 7'd9, 16'h1234);
    cmd(4'd7, 7'd9, 16'hFFFF);
    cmd(4'd1, 7'd9, 16'h0);
    cmd(4'd0, 7'd0, 16'h0);
    expect_rd("R11 stored result kept", 3'd5, 32'hABCD);
    expect_rd("R4 opcode 7 pushes", 3'd5, 32'hABCD);
    expect_rd("R2 read pushes previous", 3'd5, 32'hABCD);
    expect_rd("R4 opcode 7 left bank", 3'd5, 32'h1234);
  endtask

  task automatic t_empty;
    expect_rd("R6 empty read", 3'd5, 32'h0);
    expect_rd("R6 level unchanged", 3'd3, 32'h0500);
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < 17; i++) cmd(4'd0, 7'd0, 16'h0);
    expect_rd("R7 full status", 3'd3, 32'hF600);
    for (int i = 0; i < 15; i++) begin
      rd(3'd5, v);
      check("R5 full drain order", v, 32'h1234);
    end
    expect_rd("R7 no extra entry", 3'd3, 32'h0500);
  endtask

  task automatic t_irq;
    wr(3'd1, 32'h3ff);
    expect_rd("R8 flags cleared", 3'd1, 32'h0);
    wr(3'd2, 32'hFFFF_F0F0);
    expect_rd("R10 mask low bits", 3'd2, 32'h0F0);
    wr(3'd2, 32'h0FF);
    wr(3'd0, 32'h0002_1114);
    cmd(4'd0, 7'd0, 16'h0);
    cmd(4'd0, 7'd0, 16'h0);
    expect_rd("R8 at threshold", 3'd1, 32'h0);
    cmd(4'd0, 7'd0, 16'h0);
    @(negedge clk);
    expect_rd("R8 above threshold", 3'd1, 32'h100);
    check("R10 irq unmasked", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h1FF);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h100);
    expect_rd("R8 re-sets while held", 3'd1, 32'h100);
    wr(3'd6, 32'h10);
    wr(3'd1, 32'h100);
    expect_rd("R8 cleared", 3'd1, 32'h0);
    wr(3'd0, 32'h0010_1114);
    @(negedge clk);
    expect_rd("R9 cmd threshold", 3'd1, 32'h200);
    wr(3'd2, 32'h0);
    check("R10 irq bit9", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h0000_1114);
    wr(3'd1, 32'h3ff);
    expect_rd("R9 cleared", 3'd1, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_alarm;
    @(negedge clk); alarm_in = 8'h05;
    @(negedge clk); @(negedge clk);
    expect_rd("R12 status live", 3'd3, 32'h0505);
    alarm_in = 8'h00;
    @(negedge clk);
    expect_rd("R12 sticky flag", 3'd1, 32'h005);
    expect_rd("R12 status follows", 3'd3, 32'h0500);
    wr(3'd1, 32'hFF);
    expect_rd("R12 cleared", 3'd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lag();
    t_ops();
    t_empty();
    t_full();
    t_irq();
    t_alarm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule